// File: doc/BRIEF.md
# Configuration Transaction Bridge Register Controller

This block is a bank of 32-bit registers on a simple memory-mapped bus that lets software issue one PCIe configuration transaction at a time. Software fills four descriptor words and a write-data word. It then sets a trigger bit. The block copies those five words into a request payload and presents it on a valid/ready request port. It waits for a single-cycle response, then records completion in two status registers. Returned read data, when present, lands in a dedicated return register.

The same bank also collects four legacy INTx level inputs into an interrupt status register. It drives one interrupt output, which is high when any status bit is also set in the interrupt enable register. The INTx bits always follow their inputs and cannot be cleared by software. A software acknowledge of the done flag also drops the transmit-complete flag that sits in the transaction status register.

The bus is 256 bytes wide. The word index is the byte address shifted right by two. Reads return the addressed word in the same cycle, with no wait states.

Top module: `cfgb_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq_out` is low and `req_valid` is low.
- R2: A write to any offset other than 0x00, 0x08, 0x24 and 0xC8 stores the written word unchanged. A read returns the addressed word combinationally in the same cycle.
- R3: Writing 0x00 with bit 4 set makes the word at 0x0C all ones, and a write to 0x00 with bit 4 clear leaves 0x0C as it was. Offsets 0x00 and 0x08 always read zero.
- R4: Writing 0x24 with bit 0 set while no transaction is pending raises `req_valid` from the next cycle. The payload carries the words at 0x10, 0x14, 0x18 and 0x1C in `req_desc` (0x10 in bits 31:0, rising from there) and the word at 0x20 in `req_wdata`, as they stood at the trigger. The payload holds until `req_ready` is seen high.
- R5: A trigger write while a transaction is pending (request not yet accepted, or response not yet received) has no effect: the payload is unchanged and no further request follows.
- R6: Once the request is accepted, the first cycle with `resp_valid` high completes the transaction. From the next cycle, bit 4 (done) of 0xC8, bit 25 (transmit-complete) of 0x24 and bit 31 (idle) of 0x24 are set. If `resp_has_data` is high, 0xCC holds `resp_rdata` from that same next cycle.
- R7: Writing 0x08 with bit 0 set clears bit 31 of 0x24.
- R8: Bits 3:0 of 0xC8 follow `intx_in[3:0]` one cycle later. `irq_out` is high exactly when the status word at 0xC8 ANDed with the enable word at 0xC4 is nonzero.
- R9: Writing 0xC8 clears bit 4 where the data has bit 4 set, and then also clears bit 25 of 0x24. Bits 3:0 of 0xC8 are not affected by the write.
- R10: When a completion falls in the same cycle as a software clear of done (0xC8), a software clear of idle (0x08) or a software write to 0xCC, the completion wins. The status bits end set, and 0xCC holds the response data.
- R11: Writes to 0x24 store nothing. Bit 0 of 0x24 always reads zero, and a write with bit 0 clear starts no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed word |
| intx_in | input | N_INTX | Legacy interrupt levels |
| irq_out | output | 1 | Combined interrupt |
| req_valid | output | 1 | Configuration request pending |
| req_ready | input | 1 | Request accepted downstream |
| req_desc | output | N_DESC*DATA_W | Latched descriptor words |
| req_wdata | output | DATA_W | Latched write-data word |
| resp_valid | input | 1 | Response for the accepted request |
| resp_has_data | input | 1 | Response carries read data |
| resp_rdata | input | DATA_W | Returned read data |

## Verification
Two pieces of logic can act in the same cycle. The completion of a transaction sets the done, transmit-complete and idle bits and may load 0xCC. In that same cycle, a software bus write may clear or overwrite those same locations. The bench provokes this by holding `resp_valid` high in the cycle a write to 0xC8, 0x08 or 0xCC is issued. It then reads the registers back and expects the completion side to survive each time. A second overlap is a trigger write issued while a request is still pending; it is judged by an unchanged payload and the absence of any second request.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
   // word indices (byte offset >> 2)
   localparam int IDX_CTRL  = 0;
   localparam int IDX_TXCLR = 2;
   localparam int IDX_RDATA = 3;
   localparam int IDX_DESC0 = 4;
   localparam int IDX_WDATA = 8;
   localparam int IDX_TXSTS = 9;
   localparam int IDX_IEN   = 49;
   localparam int IDX_ISTS  = 50;
   localparam int IDX_RSP   = 51;
   // bit positions
   localparam int RXCLR_BIT   = 4;
   localparam int TRIG_BIT    = 0;
   localparam int IDLECLR_BIT = 0;
   localparam int COMP_BIT    = 25;
   localparam int IDLE_BIT    = 31;
   localparam int DONE_BIT    = 4;

   typedef enum logic [1:0] {TX_IDLE, TX_REQ, TX_WAIT} txn_state_t;
endpackage

// File: rtl/cfgb_store.sv
module cfgb_store #(
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 6,
   localparam int N_WORDS = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              a_we,
   input  logic [IDX_W-1:0]  a_idx,
   input  logic [DATA_W-1:0] a_data,
   input  logic              b_we,
   input  logic [IDX_W-1:0]  b_idx,
   input  logic [DATA_W-1:0] b_data,
   output logic [DATA_W-1:0] q [N_WORDS]
);
   import cfgb_pkg::*;

   for (genvar i = 0; i < N_WORDS; i++) begin : g_word
      if (i == IDX_CTRL || i == IDX_TXCLR || i == IDX_TXSTS || i == IDX_ISTS) begin : g_none
         assign q[i] = '0;
      end else begin : g_reg
         logic [DATA_W-1:0] word_r;
         always_ff @(posedge clk) begin
            if (rst)                                word_r <= '0;
            else if (b_we && b_idx == IDX_W'(i))    word_r <= b_data;
            else if (a_we && a_idx == IDX_W'(i))    word_r <= a_data;
         end
         assign q[i] = word_r;
      end
   end
endmodule

// File: rtl/cfgb_txn.sv
module cfgb_txn #(
   parameter int DATA_W = 32,
   parameter int N_DESC = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     trig,
   input  logic [DATA_W-1:0]        desc_in [N_DESC],
   input  logic [DATA_W-1:0]        wdata_in,
   input  logic                     req_ready,
   input  logic                     resp_valid,
   output logic                     req_valid,
   output logic [N_DESC*DATA_W-1:0] req_desc,
   output logic [DATA_W-1:0]        req_wdata,
   output logic                     cmpl,
   output logic                     busy
);
   import cfgb_pkg::*;

   txn_state_t        state;
   logic [DATA_W-1:0] desc_q [N_DESC];
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= TX_IDLE;
         wdata_q <= '0;
         for (int i = 0; i < N_DESC; i++) desc_q[i] <= '0;
      end else begin
         case (state)
            TX_IDLE: if (trig) begin
               state   <= TX_REQ;
               wdata_q <= wdata_in;
               for (int i = 0; i < N_DESC; i++) desc_q[i] <= desc_in[i];
            end
            TX_REQ:  if (req_ready)  state <= TX_WAIT;
            TX_WAIT: if (resp_valid) state <= TX_IDLE;
            default: state <= TX_IDLE;
         endcase
      end
   end

   for (genvar i = 0; i < N_DESC; i++) begin : g_pack
      assign req_desc[i*DATA_W +: DATA_W] = desc_q[i];
   end

   assign req_wdata = wdata_q;
   assign req_valid = (state == TX_REQ);
   assign cmpl      = (state == TX_WAIT) && resp_valid;
   assign busy      = (state != TX_IDLE);

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_desc) && $stable(req_wdata)));
   // R5
   busy_trig_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && trig) |=> ($stable(req_desc) && $stable(req_wdata)));
   // R6
   cmpl_free_chk: assert property (@(posedge clk) disable iff (rst)
      cmpl |=> !busy);
endmodule

// File: rtl/cfgb_irq.sv
module cfgb_irq #(
   parameter int DATA_W = 32,
   parameter int N_INTX = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [N_INTX-1:0] intx_in,
   input  logic              cmpl,
   input  logic              done_clr,
   input  logic [DATA_W-1:0] ien,
   output logic [DATA_W-1:0] sts_word,
   output logic              irq_out
);
   import cfgb_pkg::*;

   logic [N_INTX-1:0] intx_q;
   logic              done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         intx_q <= '0;
         done_q <= 1'b0;
      end else begin
         intx_q <= intx_in;
         if (cmpl)          done_q <= 1'b1;
         else if (done_clr) done_q <= 1'b0;
      end
   end

   always_comb begin
      sts_word = '0;
      sts_word[N_INTX-1:0] = intx_q;
      sts_word[DONE_BIT]   = done_q;
   end

   assign irq_out = |(sts_word & ien);

   // R8
   intx_follow_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (sts_word[N_INTX-1:0] == $past(intx_in)));
   // R6
   done_set_chk: assert property (@(posedge clk) disable iff (rst)
      cmpl |=> sts_word[DONE_BIT]);
   // R9
   done_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (done_clr && !cmpl) |=> !sts_word[DONE_BIT]);
endmodule

// File: rtl/cfgb_ctrl.sv
module cfgb_ctrl #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int N_INTX = 4,
   parameter int N_DESC = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     bus_sel,
   input  logic                     bus_wr,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   input  logic [N_INTX-1:0]        intx_in,
   output logic                     irq_out,
   output logic                     req_valid,
   input  logic                     req_ready,
   output logic [N_DESC*DATA_W-1:0] req_desc,
   output logic [DATA_W-1:0]        req_wdata,
   input  logic                     resp_valid,
   input  logic                     resp_has_data,
   input  logic [DATA_W-1:0]        resp_rdata
);
   import cfgb_pkg::*;

   localparam int IDX_W   = ADDR_W - 2;
   localparam int N_WORDS = 1 << IDX_W;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover the 256-byte window");
   end
   if (DATA_W < IDLE_BIT + 1) begin : g_bad_data
      $error("DATA_W too narrow for the status bits");
   end
   if (N_INTX < 1 || N_INTX > DONE_BIT) begin : g_bad_intx
      $error("N_INTX must be 1..4");
   end
   if (IDX_DESC0 + N_DESC > IDX_WDATA) begin : g_bad_desc
      $error("descriptor words overlap the write-data word");
   end

   logic [IDX_W-1:0]  widx;
   logic              wr_hit, hit_ctrl, hit_txclr, hit_txsts, hit_ists;
   logic              a_we;
   logic [IDX_W-1:0]  a_idx;
   logic [DATA_W-1:0] a_data;
   logic [DATA_W-1:0] q [N_WORDS];
   logic [DATA_W-1:0] desc_w [N_DESC];
   logic [DATA_W-1:0] sts_word, tx_word;
   logic              trig, cmpl, busy, done_clr;
   logic              tx_idle, tx_comp;

   assign widx      = bus_addr[ADDR_W-1:2];
   assign wr_hit    = bus_sel && bus_wr;
   assign hit_ctrl  = wr_hit && (widx == IDX_W'(IDX_CTRL));
   assign hit_txclr = wr_hit && (widx == IDX_W'(IDX_TXCLR));
   assign hit_txsts = wr_hit && (widx == IDX_W'(IDX_TXSTS));
   assign hit_ists  = wr_hit && (widx == IDX_W'(IDX_ISTS));

   assign trig     = hit_txsts && bus_wdata[TRIG_BIT];
   assign done_clr = hit_ists && bus_wdata[DONE_BIT];

   // software port: control bit 4 is turned into an all-ones write of the rx word
   assign a_we   = wr_hit && (!hit_ctrl || bus_wdata[RXCLR_BIT]);
   assign a_idx  = hit_ctrl ? IDX_W'(IDX_RDATA) : widx;
   assign a_data = hit_ctrl ? '1 : bus_wdata;

   cfgb_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_store (
      .clk    (clk),
      .rst    (rst),
      .a_we   (a_we),
      .a_idx  (a_idx),
      .a_data (a_data),
      .b_we   (cmpl && resp_has_data),
      .b_idx  (IDX_W'(IDX_RSP)),
      .b_data (resp_rdata),
      .q      (q)
   );

   for (genvar i = 0; i < N_DESC; i++) begin : g_desc
      assign desc_w[i] = q[IDX_DESC0 + i];
   end

   cfgb_txn #(.DATA_W(DATA_W), .N_DESC(N_DESC)) i_txn (
      .clk        (clk),
      .rst        (rst),
      .trig       (trig),
      .desc_in    (desc_w),
      .wdata_in   (q[IDX_WDATA]),
      .req_ready  (req_ready),
      .resp_valid (resp_valid),
      .req_valid  (req_valid),
      .req_desc   (req_desc),
      .req_wdata  (req_wdata),
      .cmpl       (cmpl),
      .busy       (busy)
   );

   cfgb_irq #(.DATA_W(DATA_W), .N_INTX(N_INTX)) i_irq (
      .clk      (clk),
      .rst      (rst),
      .intx_in  (intx_in),
      .cmpl     (cmpl),
      .done_clr (done_clr),
      .ien      (q[IDX_IEN]),
      .sts_word (sts_word),
      .irq_out  (irq_out)
   );

   // transaction status: completion has priority over software clears
   always_ff @(posedge clk) begin
      if (rst) begin
         tx_idle <= 1'b0;
         tx_comp <= 1'b0;
      end else begin
         if (cmpl)                                     tx_idle <= 1'b1;
         else if (hit_txclr && bus_wdata[IDLECLR_BIT]) tx_idle <= 1'b0;
         if (cmpl)          tx_comp <= 1'b1;
         else if (done_clr) tx_comp <= 1'b0;
      end
   end

   always_comb begin
      tx_word = '0;
      tx_word[IDLE_BIT] = tx_idle;
      tx_word[COMP_BIT] = tx_comp;
   end

   always_comb begin
      if (widx == IDX_W'(IDX_TXSTS))      bus_rdata = tx_word;
      else if (widx == IDX_W'(IDX_ISTS))  bus_rdata = sts_word;
      else                                bus_rdata = q[widx];
   end

   // R7
   idle_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (hit_txclr && bus_wdata[IDLECLR_BIT] && !cmpl) |=> !tx_idle);
   // R10
   cmpl_wins_chk: assert property (@(posedge clk) disable iff (rst)
      cmpl |=> (tx_idle && tx_comp));
   // R9
   comp_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (done_clr && !cmpl) |=> !tx_comp);
   // R11
   no_trig_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy && !trig) |=> !req_valid);
endmodule

// File: tb/test_cfgb_ctrl.sv
module test_cfgb_ctrl;
   localparam int CLK_PER = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         bus_sel = 0, bus_wr = 0;
   logic [7:0]   bus_addr = 0;
   logic [31:0]  bus_wdata = 0;
   logic [31:0]  bus_rdata;
   logic [3:0]   intx_in = 0;
   logic         irq_out, req_valid;
   logic         req_ready = 0;
   logic [127:0] req_desc;
   logic [31:0]  req_wdata;
   logic         resp_valid = 0, resp_has_data = 0;
   logic [31:0]  resp_rdata = 0;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   cfgb_ctrl i_cfgb_ctrl (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .intx_in(intx_in), .irq_out(irq_out), .req_valid(req_valid),
      .req_ready(req_ready), .req_desc(req_desc), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_has_data(resp_has_data), .resp_rdata(resp_rdata)
   );

   always #(CLK_PER/2) clk = ~clk;

   // behavioural reference
   logic [31:0] m_mem [64];
   logic [31:0] m_rq [5];
   int          m_st;      // 0 free, 1 requesting, 2 awaiting response
   logic        m_done, m_txc, m_idle;
   logic [3:0]  m_intx;

   function automatic logic [31:0] m_read(int idx);
      if (idx == 0 || idx == 2) return 32'h0;
      if (idx == 9)  return {m_idle, 5'b0, m_txc, 25'b0};
      if (idx == 50) return {27'b0, m_done, m_intx};
      return m_mem[idx];
   endfunction

   task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      int  idx;
      bit  w, cm, tg;
      #1;
      chk(32'(irq_out), 32'(|({m_done, m_intx} & m_mem[49][4:0])), "R8 irq vs model");
      chk(32'(req_valid), 32'(m_st == 1), "R4 req_valid vs model");
      chk(bus_rdata, m_read(int'(bus_addr >> 2)), "R2 rdata vs model");
      if (m_st == 1) begin
         for (int k = 0; k < 4; k++) chk(req_desc[k*32 +: 32], m_rq[k], "R4 desc vs model");
         chk(req_wdata, m_rq[4], "R4 wdata vs model");
      end
      if (rst) begin
         foreach (m_mem[k]) m_mem[k] = 0;
         foreach (m_rq[k]) m_rq[k] = 0;
         m_st = 0; m_done = 0; m_txc = 0; m_idle = 0; m_intx = 0;
      end else begin
         w   = bus_sel && bus_wr;
         idx = int'(bus_addr >> 2);
         cm  = (m_st == 2) && resp_valid;
         tg  = w && idx == 9 && bus_wdata[0] && m_st == 0;
         if (tg) begin
            for (int k = 0; k < 4; k++) m_rq[k] = m_mem[4+k];
            m_rq[4] = m_mem[8];
         end
         if (w && idx == 0 && bus_wdata[4]) m_mem[3] = 32'hFFFF_FFFF;
         if (w && idx != 0 && idx != 2 && idx != 9 && idx != 50) m_mem[idx] = bus_wdata;
         if (cm && resp_has_data) m_mem[51] = resp_rdata;
         if (w && idx == 2 && bus_wdata[0]) m_idle = 0;
         if (w && idx == 50 && bus_wdata[4]) begin m_done = 0; m_txc = 0; end
         if (cm) begin m_done = 1; m_txc = 1; m_idle = 1; end
         m_intx = intx_in;
         if (m_st == 0 && tg) m_st = 1;
         else if (m_st == 1 && req_ready) m_st = 2;
         else if (cm) m_st = 0;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      step();
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 chk(bus_rdata, exp, tag);
      step();
      bus_sel = 0;
   endtask

   task automatic accept();
      req_ready = 1; step(); req_ready = 0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PER * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      @(negedge clk);
      step(); step();
      rst = 0;
      // R1 reset state
      rd_chk(8'h24, 32'h0, "R1 txsts");
      rd_chk(8'hC8, 32'h0, "R1 ists");
      rd_chk(8'h10, 32'h0, "R1 desc0");
      chk(32'(irq_out), 0, "R1 irq");
      chk(32'(req_valid), 0, "R1 req_valid");
      // R2 plain storage
      wr(8'h10, 32'hA000_0010); wr(8'h14, 32'hA000_0014);
      wr(8'h18, 32'hA000_0018); wr(8'h1C, 32'hA000_001C);
      wr(8'h20, 32'hD000_0020); wr(8'h40, 32'h5A5A_A5A5);
      rd_chk(8'h18, 32'hA000_0018, "R2 desc2");
      rd_chk(8'h40, 32'h5A5A_A5A5, "R2 spare word");
      rd_chk(8'h20, 32'hD000_0020, "R2 wdata");
      // R3 rx clear
      wr(8'h0C, 32'h0000_1234);
      rd_chk(8'h0C, 32'h0000_1234, "R2 rdata word");
      wr(8'h00, 32'h0000_0010);
      rd_chk(8'h0C, 32'hFFFF_FFFF, "R3 rx cleared");
      rd_chk(8'h00, 32'h0, "R3 ctrl reads zero");
      wr(8'h0C, 32'h77);
      wr(8'h00, 32'hEF);
      rd_chk(8'h0C, 32'h77, "R3 no clear without bit4");
      rd_chk(8'h08, 32'h0, "R3 txclr reads zero");
      // R4 trigger
      wr(8'hC4, 32'h10);
      wr(8'h24, 32'h1);
      #1 chk(32'(req_valid), 1, "R4 request raised");
      chk(req_desc[31:0], 32'hA000_0010, "R4 desc0");
      chk(req_desc[127:96], 32'hA000_001C, "R4 desc3");
      chk(req_wdata, 32'hD000_0020, "R4 wdata");
      // R5 busy trigger
      wr(8'h10, 32'hB000_0010);
      wr(8'h24, 32'h1);
      chk(req_desc[31:0], 32'hA000_0010, "R5 payload kept");
      accept();
      chk(32'(req_valid), 0, "R4 dropped after ready");
      step();
      resp_valid = 1; resp_has_data = 1; resp_rdata = 32'hCAFE_0001;
      step();
      resp_valid = 0; resp_has_data = 0;
      rd_chk(8'h24, 32'h8200_0000, "R6 comp and idle");
      rd_chk(8'hC8, 32'h10, "R6 done");
      rd_chk(8'hCC, 32'hCAFE_0001, "R6 read data");
      chk(32'(irq_out), 1, "R8 done enabled");
      step(); step();
      chk(32'(req_valid), 0, "R5 no queued request");
      // R7
      wr(8'h08, 32'h1);
      rd_chk(8'h24, 32'h0200_0000, "R7 idle cleared");
      // R8 / R9
      intx_in = 4'b0101; step();
      rd_chk(8'hC8, 32'h15, "R8 intx visible");
      wr(8'hC8, 32'h1F);
      rd_chk(8'hC8, 32'h05, "R9 intx kept");
      rd_chk(8'h24, 32'h0, "R9 comp cleared");
      chk(32'(irq_out), 0, "R8 intx not enabled");
      wr(8'hC4, 32'h04);
      chk(32'(irq_out), 1, "R8 intx enabled");
      intx_in = 4'b0000; step();
      chk(32'(irq_out), 0, "R8 intx dropped");
      rd_chk(8'hC8, 32'h0, "R8 status follows");
      // R11
      wr(8'h24, 32'hFFFF_FFFE);
      rd_chk(8'h24, 32'h0, "R11 not stored");
      chk(32'(req_valid), 0, "R11 no trigger");
      // R10 collisions
      wr(8'h24, 32'h1);
      chk(req_desc[31:0], 32'hB000_0010, "R4 new desc0");
      accept();
      bus_sel = 1; bus_wr = 1; bus_addr = 8'hC8; bus_wdata = 32'h10; resp_valid = 1;
      step();
      bus_sel = 0; bus_wr = 0; resp_valid = 0;
      rd_chk(8'hC8, 32'h10, "R10 done survives");
      rd_chk(8'h24, 32'h8200_0000, "R10 comp survives");
      wr(8'h24, 32'h1);
      accept();
      bus_sel = 1; bus_wr = 1; bus_addr = 8'h08; bus_wdata = 32'h1; resp_valid = 1;
      step();
      bus_sel = 0; bus_wr = 0; resp_valid = 0;
      rd_chk(8'h24, 32'h8200_0000, "R10 idle survives");
      rd_chk(8'hCC, 32'hCAFE_0001, "R6 no data keeps return word");
      wr(8'h24, 32'h1);
      accept();
      bus_sel = 1; bus_wr = 1; bus_addr = 8'hCC; bus_wdata = 32'h55;
      resp_valid = 1; resp_has_data = 1; resp_rdata = 32'h600D_0003;
      step();
      bus_sel = 0; bus_wr = 0; resp_valid = 0; resp_has_data = 0;
      rd_chk(8'hCC, 32'h600D_0003, "R10 response data wins");
      step();
      finish_run();
   end
endmodule